// File: doc/BRIEF.md
# Supply-Path Latch-Up Trip Supervisor

This block watches one protected supply path for the current surge that a parasitic latch-up causes. An external sense amplifier and ADC deliver load-current samples. Software programs the normal maximum current of the load. When any valid sample is larger than twice that maximum, the supervisor opens the series power switch on the next clock edge. It then turns on a shunt switch that draws the remaining charge away from the load.

The shunt is held on for a blanking time given in microseconds. That time is turned into clock cycles from the clock frequency. After blanking, power comes back by itself, and break-before-make gaps are kept on both transitions. Each trip sets a sticky interrupt that the host clears with an acknowledge strobe. Each trip also increments a saturating event counter.

While the load is off, incoming samples are ignored. The surge that is still dying away therefore cannot start a second trip.

Top module: `lu_trip_ctrl`

## Requirements
- R1: After reset, iso_en_o is 1, shunt_en_o is 0, irq_o is 0 and trip_cnt_o is 0.
- R2: While powered, a cycle with sample_vld_i=1 and sample_i strictly greater than 2*imax_i (unsigned) trips the block. iso_en_o is 0 from the next clock edge on. A sample equal to 2*imax_i does not trip.
- R3: After iso_en_o falls, both enables are 0 for exactly one cycle. Then shunt_en_o becomes 1.
- R4: shunt_en_o stays 1 for exactly BLANK_CYC = CLK_FREQ_HZ*BLANK_US/1e6 cycles.
- R5: After shunt_en_o falls, both enables are 0 for exactly one cycle. Then iso_en_o returns to 1 without outside action.
- R6: Samples that arrive while iso_en_o is 0 have no effect. No new trip occurs, and trip_cnt_o and the timing of R3 to R5 are unchanged.
- R7: irq_o becomes 1 on the edge that trips. It stays 1 until a cycle with irq_ack_i=1 and no trip, and then clears on the following edge. A trip and an acknowledge in the same cycle leave irq_o at 1.
- R8: trip_cnt_o increases by one per trip and stops at 2^CNT_W-1.
- R9: A sample with sample_vld_i=0 never trips, whatever its value.
- R10: iso_en_o and shunt_en_o are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | CUR_W | Load-current sample from the ADC |
| sample_vld_i | input | 1 | sample_i is valid this cycle |
| imax_i | input | CUR_W | Normal maximum load current, same scale as sample_i |
| irq_ack_i | input | 1 | Host acknowledge; clears irq_o |
| iso_en_o | output | 1 | Series switch closed (load powered) |
| shunt_en_o | output | 1 | Shunt switch closed (residual current diverted) |
| irq_o | output | 1 | Sticky trip interrupt |
| trip_cnt_o | output | CNT_W | Saturating trip counter |

## Verification
Two events can land on the same edge: the host acknowledges the interrupt while a new over-threshold sample trips the block. The set must win over the clear. This case is forced directly right after a restore, and it also comes up on its own in the random stimulus, where acknowledges are frequent. A per-cycle reference model built from R7 gives the result. The other overlap is the counter at its ceiling when a trip arrives. A counter only three bits wide makes this common, and the model checks that the count holds at its maximum.

// File: rtl/lu_trip_pkg.sv
package lu_trip_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_OPEN    = 2'd1,
    ST_BLANK   = 2'd2,
    ST_RELEASE = 2'd3
  } lu_state_e;
endpackage

// File: rtl/lu_trip_detect.sv
module lu_trip_detect #(
  parameter int unsigned CUR_W = 12
) (
  input  logic [CUR_W-1:0] sample_i,
  input  logic             sample_vld_i,
  input  logic [CUR_W-1:0] imax_i,
  output logic             over_o
);
  localparam int unsigned CMP_W = CUR_W + 1;

  logic [CMP_W-1:0] limit;
  logic [CMP_W-1:0] sample_ext;

  // threshold is twice the nominal maximum, one extra bit avoids overflow
  assign limit      = {imax_i, 1'b0};
  assign sample_ext = {1'b0, sample_i};
  assign over_o     = sample_vld_i && (sample_ext > limit);
endmodule

// File: rtl/lu_blank_timer.sv
module lu_blank_timer #(
  parameter int unsigned BLANK_CYC = 20,
  parameter int unsigned TMR_W     = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic done_o
);
  localparam logic [TMR_W-1:0] LOAD_VAL = TMR_W'(BLANK_CYC - 1);

  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= LOAD_VAL;
    else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  a_r4_load_not_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && BLANK_CYC > 1) |=> !done_o);
endmodule

// File: rtl/lu_irq_count.sv
module lu_irq_count #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trip_i,
  input  logic             ack_i,
  output logic             irq_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             irq_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     irq_q <= 1'b0;
    else if (trip_i) irq_q <= 1'b1;   // set wins over ack
    else if (ack_i)  irq_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (trip_i && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
  end

  assign irq_o = irq_q;
  assign cnt_o = cnt_q;

  a_r7_irq_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_i |=> irq_o);
  a_r7_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack_i) |=> irq_o);
  a_r8_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == CNT_MAX) |=> (cnt_o == CNT_MAX));
  a_r8_increment: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trip_i && cnt_o != CNT_MAX) |=> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/lu_trip_ctrl.sv
module lu_trip_ctrl #(
  parameter int unsigned CUR_W       = 12,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned CLK_FREQ_HZ = 50_000_000,
  parameter int unsigned BLANK_US    = 100_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CUR_W-1:0] sample_i,
  input  logic             sample_vld_i,
  input  logic [CUR_W-1:0] imax_i,
  input  logic             irq_ack_i,
  output logic             iso_en_o,
  output logic             shunt_en_o,
  output logic             irq_o,
  output logic [CNT_W-1:0] trip_cnt_o
);
  import lu_trip_pkg::*;

  localparam longint unsigned BLANK_L   = (longint'(CLK_FREQ_HZ) * longint'(BLANK_US)) / 64'd1_000_000;
  localparam int unsigned     BLANK_CYC = (BLANK_L < 1) ? 1 : int'(BLANK_L);
  localparam int unsigned     TMR_W     = $clog2(BLANK_CYC + 1);

  lu_state_e state_q, state_d;
  logic      over;
  logic      trip;
  logic      tmr_done;

  lu_trip_detect #(.CUR_W(CUR_W)) u_detect (
    .sample_i     (sample_i),
    .sample_vld_i (sample_vld_i),
    .imax_i       (imax_i),
    .over_o       (over)
  );

  // samples are only honoured while the load is powered
  assign trip = over && (state_q == ST_RUN);

  lu_blank_timer #(.BLANK_CYC(BLANK_CYC), .TMR_W(TMR_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (state_q == ST_OPEN),
    .run_i  (state_q == ST_BLANK),
    .done_o (tmr_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:     if (trip) state_d = ST_OPEN;
      ST_OPEN:    state_d = ST_BLANK;
      ST_BLANK:   if (tmr_done) state_d = ST_RELEASE;
      ST_RELEASE: state_d = ST_RUN;
      default:    state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  assign iso_en_o   = (state_q == ST_RUN);
  assign shunt_en_o = (state_q == ST_BLANK);

  lu_irq_count #(.CNT_W(CNT_W)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trip_i (trip),
    .ack_i  (irq_ack_i),
    .irq_o  (irq_o),
    .cnt_o  (trip_cnt_o)
  );

  a_r10_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(iso_en_o && shunt_en_o));
  a_r2_fast_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iso_en_o && over) |=> !iso_en_o);
  a_r3_gap_before_shunt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shunt_en_o) |-> !$past(iso_en_o));
  a_r5_gap_before_power: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(iso_en_o) |-> !$past(shunt_en_o));
  a_r6_no_count_while_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iso_en_o |=> $stable(trip_cnt_o));
endmodule

// File: tb/lu_trip_ctrl_bench.sv
module lu_trip_ctrl_bench;
  localparam int unsigned CUR_W   = 12;
  localparam int unsigned CNT_W   = 3;
  localparam int unsigned FREQ    = 1_000_000;
  localparam int unsigned BUS     = 20;
  localparam int          B       = FREQ / 1000 * BUS / 1000;
  localparam int          CNT_MAX = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CUR_W-1:0] sample = '0;
  logic             vld = 1'b0;
  logic [CUR_W-1:0] imax = '0;
  logic             ack = 1'b0;
  logic             iso, shunt, irq;
  logic [CNT_W-1:0] cnt;

  int checks = 0;
  int errors = 0;
  int ph = 0;
  int irq_e = 0;
  int cnt_e = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  lu_trip_ctrl #(.CUR_W(CUR_W), .CNT_W(CNT_W), .CLK_FREQ_HZ(FREQ), .BLANK_US(BUS)) u_lu_trip_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .sample_vld_i(vld), .imax_i(imax),
    .irq_ack_i(ack), .iso_en_o(iso), .shunt_en_o(shunt), .irq_o(irq), .trip_cnt_o(cnt)
  );

  function automatic bit exp_trip(int p, bit v, int s, int m);
    return (p == 0) && v && (s > 2 * m);
  endfunction
  function automatic int exp_iso(int p);   return (p == 0) ? 1 : 0; endfunction
  function automatic int exp_shunt(int p); return (p >= 2 && p <= B + 1) ? 1 : 0; endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // drive one cycle, advance model, then check at the following negedge
  task automatic step(bit v, int s, int m, bit a);
    bit t;
    string rq_i, rq_s;
    vld = v; sample = CUR_W'(s); imax = CUR_W'(m); ack = a;
    t = exp_trip(ph, v, s, m);
    if (ph == 0) ph = t ? 1 : 0;
    else ph = (ph == B + 2) ? 0 : ph + 1;
    irq_e = (t || (irq_e != 0 && !a)) ? 1 : 0;
    if (t && cnt_e < CNT_MAX) cnt_e++;
    @(posedge clk); @(negedge clk);
    cyc++;
    rq_i = (ph == 1) ? "R2" : (ph == B + 2) ? "R5" : (ph == 0) ? "R6" : "R4";
    rq_s = (ph == 2) ? "R3" : (ph == B + 2) ? "R5" : "R4";
    check(iso == exp_iso(ph), rq_i, "iso_en", int'(iso), exp_iso(ph));
    check(shunt == exp_shunt(ph), rq_s, "shunt_en", int'(shunt), exp_shunt(ph));
    check(!(iso && shunt), "R10", "both on", int'(iso && shunt), 0);
    check(int'(irq) == irq_e, "R7", "irq", int'(irq), irq_e);
    check(int'(cnt) == cnt_e, "R8", "trip_cnt", int'(cnt), cnt_e);
  endtask

  task automatic wait_run();
    while (ph != 0) step(1'b1, 4095, 10, 1'b0);   // R6: over-limit junk while off
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 150_000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int s, m;
    bit v, a;
    void'($urandom(32'd20240611));
    @(negedge clk); @(negedge clk);
    check(iso == 1'b1, "R1", "reset iso", int'(iso), 1);
    check(shunt == 1'b0, "R1", "reset shunt", int'(shunt), 0);
    check(irq == 1'b0, "R1", "reset irq", int'(irq), 0);
    check(cnt == '0, "R1", "reset cnt", int'(cnt), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 boundary: equal to 2*imax holds, one above trips
    step(1'b1, 200, 100, 1'b0);
    check(iso == 1'b1, "R2", "equal no trip", int'(iso), 1);
    // R9: huge sample without valid
    step(1'b0, 4095, 0, 1'b0);
    check(iso == 1'b1, "R9", "invalid no trip", int'(iso), 1);
    step(1'b1, 201, 100, 1'b0);
    check(iso == 1'b0, "R2", "above trips", int'(iso), 0);
    wait_run();
    check(cnt == 3'd1, "R6", "no retrigger count", int'(cnt), 1);
    // R7: ack clears
    step(1'b0, 0, 0, 1'b1);
    check(irq == 1'b0, "R7", "ack clears", int'(irq), 0);
    // R7: trip and ack same cycle, set wins
    step(1'b1, 4095, 0, 1'b1);
    check(irq == 1'b1, "R7", "set beats ack", int'(irq), 1);
    wait_run();
    // R4: measure shunt width on a fresh trip
    begin
      int w = 0;
      step(1'b1, 4095, 0, 1'b0);
      while (ph != 0) begin
        step(1'b0, 0, 0, 1'b0);
        if (shunt) w++;
      end
      check(w == B, "R4", "shunt width", w, B);
    end
    // R8: drive to saturation
    for (int k = 0; k < 8; k++) begin
      step(1'b1, 4095, 1, 1'b0);
      wait_run();
    end
    check(int'(cnt) == CNT_MAX, "R8", "saturated", int'(cnt), CNT_MAX);

    for (int i = 0; i < 20000; i++) begin
      m = int'($urandom_range(0, 1000));
      v = ($urandom_range(0, 99) < 40);
      s = ($urandom_range(0, 99) < 4) ? 2 * m + int'($urandom_range(1, 50))
                                      : int'($urandom_range(0, 2 * m));
      a = ($urandom_range(0, 99) < 15);
      step(v, s, m, a);
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule